// File: doc/BRIEF.md
# Line AIS Detector with Insertion

This block watches a recovered receive bit stream, one bit per clock, for an alarm indication signal: an unframed stream that is all ones apart from occasional bit errors. It counts zeros over fixed windows of `WIN_BITS` bits. A window with fewer than `ZERO_LIMIT` zeros raises the alarm, and a window with that many zeros or more lowers it. A frame-alignment flag from the framer overrides detection, so a framed signal whose payload is all ones is never reported.

The block drives an active-low alarm pin and a live status bit, which are the same state. It also keeps a sticky status bit that a processor clears with a strobe. On the terminal side it forwards the receive data delayed by one register. While the alarm is raised or frame alignment is lost, it replaces that data with ones, unless the insertion enable input is held low.

Top module: `line_ais_detector`

## Requirements
- R1: `ais_n` is the inverse of `ais_live`. After 2*`WIN_BITS` consecutive one bits with `frame_ok` low, `ais_live` is 1.
- R2: Windows are consecutive blocks of `WIN_BITS` bits, and the first one begins with the first clock after reset is released. While `frame_ok` is low, `ais_live` changes only on the clock edge that takes in the last bit of a window.
- R3: With `frame_ok` low, a window holding fewer than `ZERO_LIMIT` zero bits (4 or fewer with the default of 5) sets `ais_live`, or keeps it set, at the end of that window.
- R4: With `frame_ok` low, a window holding `ZERO_LIMIT` or more zero bits clears `ais_live` at the end of that window.
- R5: While `frame_ok` is 1, `ais_live` is 0 from the following clock on, whatever the data.
- R6: While `rst` is high, the window position, the zero count, `ais_live`, `ais_sticky` and `term_bit` are cleared. `ais_n` is then 1.
- R7: `term_bit` is one clock later than `rx_bit`. It is 1 when `ins_allow` was 1 and either `ais_live` was 1 or `frame_ok` was 0. Otherwise it equals the earlier `rx_bit`.
- R8: `ais_sticky` goes to 1 in the same clock that `ais_live` rises. It stays at 1 after `ais_live` falls, until a clear strobe.
- R9: A `clr_latch` pulse clears `ais_sticky` one clock later. A pulse that falls in the same clock as a rise of `ais_live` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bit clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_bit | input | 1 | Received data bit, one per clock |
| frame_ok | input | 1 | Frame alignment flag from the framer, high when aligned |
| ins_allow | input | 1 | Insertion enable; low passes data through unchanged |
| clr_latch | input | 1 | Processor strobe that clears the sticky bit |
| ais_n | output | 1 | Alarm pin, active low |
| term_bit | output | 1 | Terminal-side data after substitution |
| ais_live | output | 1 | Unlatched alarm status bit |
| ais_sticky | output | 1 | Latched alarm status bit |

## Verification
The alarm status changes in the clock edge that takes in the last bit of a window. Substituted data appears one edge after its bit. The sticky bit is set in the same edge as the alarm, and a clear strobe takes effect one edge later. The bench counts every bit it drives since reset and always knows the position within the current window. It drives each bit, waits for the edge that registers it, and samples one nanosecond later. It checks the alarm one bit before a window ends, where the old value must still hold, and again just after the final bit, where the new value must appear.

// File: rtl/line_ais_detector.sv
module line_ais_detector #(
  parameter int WIN_BITS   = 1536,
  parameter int ZERO_LIMIT = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_bit,
  input  logic frame_ok,
  input  logic ins_allow,
  input  logic clr_latch,
  output logic ais_n,
  output logic term_bit,
  output logic ais_live,
  output logic ais_sticky
);
  localparam int CW = $clog2(WIN_BITS);
  localparam int ZW = $clog2(ZERO_LIMIT + 1);
  localparam int RUN_MAX = 2 * WIN_BITS;
  localparam int RW = $clog2(RUN_MAX + 1);

  logic [CW-1:0] pos;
  logic [ZW-1:0] zeros, zeros_nx;
  logic          win_end, quiet;
  logic          ais_q, ais_d, sticky_q, term_q;

  assign win_end = (pos == CW'(WIN_BITS - 1));

  always_comb begin
    zeros_nx = zeros;
    if (!rx_bit && zeros != ZW'(ZERO_LIMIT))
      zeros_nx = zeros + 1'b1;
  end

  assign quiet = (zeros_nx < ZW'(ZERO_LIMIT));
  assign ais_d = frame_ok ? 1'b0 : (win_end ? quiet : ais_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos      <= '0;
      zeros    <= '0;
      ais_q    <= 1'b0;
      sticky_q <= 1'b0;
      term_q   <= 1'b0;
    end else begin
      pos      <= win_end ? '0 : pos + 1'b1;
      zeros    <= win_end ? '0 : zeros_nx;
      ais_q    <= ais_d;
      sticky_q <= (ais_d & ~ais_q) | (sticky_q & ~clr_latch);
      term_q   <= (ins_allow && (ais_q || !frame_ok)) ? 1'b1 : rx_bit;
    end
  end

  assign ais_live   = ais_q;
  assign ais_n      = ~ais_q;
  assign ais_sticky = sticky_q;
  assign term_bit   = term_q;

  logic [RW-1:0] ones_run;
  always_ff @(posedge clk) begin
    if (rst)
      ones_run <= '0;
    else if (rx_bit && !frame_ok)
      ones_run <= (ones_run == RW'(RUN_MAX)) ? ones_run : ones_run + 1'b1;
    else
      ones_run <= '0;
  end

  AST_DETECT_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (ones_run == RW'(RUN_MAX)) |-> ais_live);                              // R1
  AST_HOLD_MIDWINDOW: assert property (@(posedge clk) disable iff (rst)
    (!win_end && !frame_ok) |=> $stable(ais_live));                        // R2
  AST_FRAMED_NO_AIS: assert property (@(posedge clk) disable iff (rst)
    frame_ok |=> !ais_live);                                               // R5
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
    !ins_allow |=> (term_bit == $past(rx_bit)));                           // R7
  AST_LOF_INSERT: assert property (@(posedge clk) disable iff (rst)
    (ins_allow && !frame_ok) |=> term_bit);                                // R7
  AST_STICKY_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(ais_live) |-> ais_sticky);                                       // R8
  AST_STICKY_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (clr_latch && !ais_d) |=> !ais_sticky);                                // R9
endmodule

// File: tb/line_ais_detector_test.sv
module line_ais_detector_test;
  localparam int W = 1536;
  localparam int LIM = 5;

  logic clk = 1'b0, rst = 1'b1, rx_bit = 1'b1, frame_ok = 1'b0;
  logic ins_allow = 1'b1, clr_latch = 1'b0;
  logic ais_n, term_bit, ais_live, ais_sticky;
  int total = 0, bad = 0, nbits = 0, cycles = 0;

  line_ais_detector #(.WIN_BITS(W), .ZERO_LIMIT(LIM)) uut (
    .clk(clk), .rst(rst), .rx_bit(rx_bit), .frame_ok(frame_ok),
    .ins_allow(ins_allow), .clr_latch(clr_latch), .ais_n(ais_n),
    .term_bit(term_bit), .ais_live(ais_live), .ais_sticky(ais_sticky));

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: cycles=%0d expected < 150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic put(input logic b);
    rx_bit = b;
    @(posedge clk); #1;
    nbits++;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    nbits = 0;
  endtask

  task automatic to_last(input logic b);
    while (nbits % W != W - 1) put(b);
  endtask

  task automatic zeros_window(input int nz);
    int k = 0;
    while (nbits % W != W - 1) begin
      put((k < nz && (nbits % W) % 200 == 7) ? 1'b0 : 1'b1);
      if ((nbits - 1) % W % 200 == 7 && k < nz) k++;
    end
  endtask

  task automatic t_reset();
    do_reset();
    check("R6 ais_n", ais_n, 1'b1);
    check("R6 ais_live", ais_live, 1'b0);
    check("R6 sticky", ais_sticky, 1'b0);
    check("R6 term_bit", term_bit, 1'b0);
  endtask

  task automatic t_detect();
    frame_ok = 1'b0;
    to_last(1'b1);
    check("R2 no alarm before window end", ais_live, 1'b0);
    put(1'b1);
    check("R3 all-ones window sets alarm", ais_live, 1'b1);
    check("R1 ais_n low", ais_n, 1'b0);
    check("R8 sticky set with alarm", ais_sticky, 1'b1);
  endtask

  task automatic t_tolerate();
    zeros_window(LIM - 1);
    put(1'b1);
    check("R3 four zeros keep alarm", ais_live, 1'b1);
  endtask

  task automatic t_release();
    zeros_window(LIM);
    check("R2 alarm held before window end", ais_live, 1'b1);
    put(1'b1);
    check("R4 five zeros clear alarm", ais_live, 1'b0);
    check("R1 ais_n high", ais_n, 1'b1);
    check("R8 sticky held after clear", ais_sticky, 1'b1);
    clr_latch = 1'b1; put(1'b1); clr_latch = 1'b0;
    check("R9 strobe clears sticky", ais_sticky, 1'b0);
  endtask

  task automatic t_coincide();
    to_last(1'b1);
    clr_latch = 1'b1; put(1'b1); clr_latch = 1'b0;
    check("R9 coincident strobe ignored", ais_sticky, 1'b1);
    clr_latch = 1'b1; put(1'b1); clr_latch = 1'b0;
    check("R9 strobe clears during alarm", ais_sticky, 1'b0);
    check("R9 alarm unaffected", ais_live, 1'b1);
  endtask

  task automatic t_framed();
    frame_ok = 1'b1;
    put(1'b1);
    check("R5 alignment drops alarm", ais_live, 1'b0);
    to_last(1'b1); put(1'b1);
    to_last(1'b1); put(1'b1);
    check("R5 framed all-ones not alarm", ais_live, 1'b0);
  endtask

  task automatic t_insert();
    ins_allow = 1'b1; frame_ok = 1'b1;
    put(1'b0);
    check("R7 aligned data passes", term_bit, 1'b0);
    frame_ok = 1'b0;
    put(1'b0);
    check("R7 loss of frame forces ones", term_bit, 1'b1);
    ins_allow = 1'b0;
    put(1'b0);
    check("R7 disabled insertion passes zero", term_bit, 1'b0);
    to_last(1'b1); put(1'b1);
    check("R3 alarm with insertion off", ais_live, 1'b1);
    put(1'b0);
    check("R7 alarm data passes when disabled", term_bit, 1'b0);
    ins_allow = 1'b1;
    put(1'b0);
    check("R7 alarm forces ones", term_bit, 1'b1);
  endtask

  task automatic t_latency();
    zeros_window(LIM + 2); put(1'b1);
    check("R4 clear before latency test", ais_live, 1'b0);
    while (nbits % W != W / 2) put(1'b0);
    for (int i = 0; i < 2 * W; i++) put(1'b1);
    check("R1 alarm within two windows", ais_live, 1'b1);
  endtask

  task automatic t_reset_mid();
    check("R6 alarm active before reset", ais_sticky | ais_live, 1'b1);
    do_reset();
    check("R6 reset clears alarm", ais_live, 1'b0);
    check("R6 reset clears sticky", ais_sticky, 1'b0);
    for (int i = 0; i < 100; i++) put(1'b1);
    to_last(1'b1);
    check("R6 window restarts at reset", ais_live, 1'b0);
    put(1'b1);
    check("R2 alarm at first window end", ais_live, 1'b1);
  endtask

  initial begin
    t_reset();
    t_detect();
    t_tolerate();
    t_release();
    t_coincide();
    t_framed();
    t_insert();
    t_latency();
    t_reset_mid();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule